// File: doc/BRIEF.md
# Predicate Bank with Compare and Writeback Gating

This block keeps a bank of one-bit predicate registers next to a simple integer datapath. It decides, instruction by instruction, whether a result may be written into the integer register file. Each writeback request carries a predicate index. The request reaches the register-file write port only if the predicate it selects holds 1. Otherwise the write is dropped.

Predicates are set by compare operations. A compare takes two 64-bit operands and a two-bit condition code. It writes its outcome into one named predicate and the inverted outcome into a second one. The compare is itself qualified by a predicate. A compiler can therefore turn a branch into two instruction streams guarded by a complementary pair. Both streams may issue, and only the stream whose guard is true changes architectural state. Predicate 0 is hardwired to 1, so an unguarded instruction names index 0.

Top module: `pred_gate_unit`

## Requirements
- R1: While reset is held, and after it is released, every predicate reads 0 except index 0, and the register-file write enable is 0.
- R2: Predicate index 0 always reads 1. A compare that names index 0 as either destination leaves it at 1.
- R3: A writeback request with valid set and a selected predicate of 1 appears on the register-file write port one clock later, with the same register index and data. With a selected predicate of 0 the write enable stays 0 in that cycle.
- R4: A qualified compare writes its outcome into the "true" destination and the inverse of the outcome into the "false" destination.
- R5: Condition code 2'b00 tests A == B, 2'b01 tests A != B, 2'b10 tests signed A < B, and 2'b11 tests unsigned A < B.
- R6: A compare whose qualifying predicate is 0 modifies no predicate.
- R7: When both destinations of a qualified compare name the same register, that register receives the outcome, not its inverse.
- R8: A predicate written by a compare changes at the clock edge. A writeback presented in the same cycle as the compare is gated by the old value, and one presented in any later cycle is gated by the new value.
- R9: Two writebacks guarded by a complementary pair produced by one compare result in exactly one committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Compare request present |
| cmpQualIdx | input | 6 | Predicate qualifying the compare |
| cmpCond | input | 2 | Condition code (see R5) |
| cmpOpA | input | 64 | First compare operand |
| cmpOpB | input | 64 | Second compare operand |
| cmpDstTrue | input | 6 | Predicate that receives the outcome |
| cmpDstFalse | input | 6 | Predicate that receives the inverted outcome |
| wbValid | input | 1 | Writeback request present |
| wbPredIdx | input | 6 | Predicate guarding the writeback |
| wbDstReg | input | 7 | Destination integer register |
| wbData | input | 64 | Result value |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrAddr | output | 7 | Register-file write index |
| rfWrData | output | 64 | Register-file write data |

## Verification
Every writeback decision is due on the write port exactly one clock after its request. The driver therefore pushes one expected item per driven cycle, and the monitor pops it shortly after the following rising edge. The monitor compares the enable, and for committed writes it also compares the index and data. A compare has no output of its own. Its effect is observed through writebacks guarded by its destinations, starting in the cycle after the compare. A writeback issued alongside the compare is predicted from the bench model before the model is updated, which checks the old-value rule.

// File: rtl/pred_gate_pkg.sv
package pred_gate_pkg;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_NE  = 2'b01,
    CMP_SLT = 2'b10,
    CMP_ULT = 2'b11
  } cmpCond_e;

  // strobes from control to the predicate datapath
  typedef struct packed {
    logic setTrue;   // write outcome into true destination
    logic setFalse;  // write inverse into false destination
    logic outcome;   // evaluated comparison result
    logic commitWb;  // writeback allowed this cycle
  } predStrobe_t;

endpackage

// File: rtl/pred_ctrl.sv
module pred_ctrl
  import pred_gate_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              cmpValid,
  input  logic [1:0]        cmpCond,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic              cmpQualBit,
  input  logic              wbValid,
  input  logic              wbQualBit,
  output predStrobe_t       strobe
);

  logic outcome;

  always_comb begin
    unique case (cmpCond_e'(cmpCond))
      CMP_EQ:  outcome = (cmpOpA == cmpOpB);
      CMP_NE:  outcome = (cmpOpA != cmpOpB);
      CMP_SLT: outcome = ($signed(cmpOpA) < $signed(cmpOpB));
      CMP_ULT: outcome = (cmpOpA < cmpOpB);
      default: outcome = 1'b0;
    endcase
  end

  always_comb begin
    strobe.outcome  = outcome;
    strobe.setTrue  = cmpValid && cmpQualBit;
    strobe.setFalse = cmpValid && cmpQualBit;
    strobe.commitWb = wbValid && wbQualBit;
  end

endmodule

// File: rtl/pred_bank.sv
module pred_bank
  import pred_gate_pkg::*;
#(
  parameter int PRED_COUNT = 64,
  parameter int DATA_W     = 64,
  parameter int REG_COUNT  = 128,
  localparam int PIDX_W    = $clog2(PRED_COUNT),
  localparam int RIDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  predStrobe_t       strobe,
  input  logic              cmpValid,
  input  logic [PIDX_W-1:0] cmpQualIdx,
  input  logic [PIDX_W-1:0] cmpDstTrue,
  input  logic [PIDX_W-1:0] cmpDstFalse,
  input  logic              wbValid,
  input  logic [PIDX_W-1:0] wbPredIdx,
  input  logic [RIDX_W-1:0] wbDstReg,
  input  logic [DATA_W-1:0] wbData,
  output logic              cmpQualBit,
  output logic              wbQualBit,
  output logic              rfWrEn,
  output logic [RIDX_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData
);

  logic [PRED_COUNT-1:0] predBits;

  // entry 0 is hardwired; the others are plain flops, the true destination
  // taking priority so a shared destination keeps the outcome
  for (genvar i = 0; i < PRED_COUNT; i++) begin : g_pred
    if (i == 0) begin : g_const
      assign predBits[i] = 1'b1;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          predBits[i] <= 1'b0;
        end else if (strobe.setTrue && cmpDstTrue == PIDX_W'(i)) begin
          predBits[i] <= strobe.outcome;
        end else if (strobe.setFalse && cmpDstFalse == PIDX_W'(i)) begin
          predBits[i] <= ~strobe.outcome;
        end
      end
    end
  end

  assign cmpQualBit = predBits[cmpQualIdx];
  assign wbQualBit  = predBits[wbPredIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rfWrEn   <= 1'b0;
      rfWrAddr <= '0;
      rfWrData <= '0;
    end else begin
      rfWrEn   <= strobe.commitWb;
      rfWrAddr <= wbDstReg;
      rfWrData <= wbData;
    end
  end

  // R2: an index-0 guarded writeback always commits
  a_r2_zero_guard_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && wbPredIdx == '0) |=> rfWrEn);

  // R3: a writeback guarded by a clear predicate never commits
  a_r3_clear_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !wbQualBit) |=> !rfWrEn);

  // R3: nothing commits without a request
  a_r3_no_phantom_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wbValid |=> !rfWrEn);

  // R4: distinct nonzero destinations end up complementary
  a_r4_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && cmpQualBit && cmpDstTrue != cmpDstFalse &&
     cmpDstTrue != '0 && cmpDstFalse != '0)
    |=> (predBits[$past(cmpDstTrue)] != predBits[$past(cmpDstFalse)]));

  // R6: an unqualified compare leaves the whole bank untouched
  a_r6_unqualified_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpValid && !cmpQualBit) |=> $stable(predBits));

endmodule

// File: rtl/pred_gate_unit.sv
module pred_gate_unit
  import pred_gate_pkg::*;
#(
  parameter int PRED_COUNT = 64,
  parameter int DATA_W     = 64,
  parameter int REG_COUNT  = 128,
  localparam int PIDX_W    = $clog2(PRED_COUNT),
  localparam int RIDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpValid,
  input  logic [PIDX_W-1:0] cmpQualIdx,
  input  logic [1:0]        cmpCond,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic [PIDX_W-1:0] cmpDstTrue,
  input  logic [PIDX_W-1:0] cmpDstFalse,
  input  logic              wbValid,
  input  logic [PIDX_W-1:0] wbPredIdx,
  input  logic [RIDX_W-1:0] wbDstReg,
  input  logic [DATA_W-1:0] wbData,
  output logic              rfWrEn,
  output logic [RIDX_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData
);

  predStrobe_t strobe;
  logic        cmpQualBit;
  logic        wbQualBit;

  pred_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .cmpValid   (cmpValid),
    .cmpCond    (cmpCond),
    .cmpOpA     (cmpOpA),
    .cmpOpB     (cmpOpB),
    .cmpQualBit (cmpQualBit),
    .wbValid    (wbValid),
    .wbQualBit  (wbQualBit),
    .strobe     (strobe)
  );

  pred_bank #(
    .PRED_COUNT (PRED_COUNT),
    .DATA_W     (DATA_W),
    .REG_COUNT  (REG_COUNT)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .cmpValid    (cmpValid),
    .cmpQualIdx  (cmpQualIdx),
    .cmpDstTrue  (cmpDstTrue),
    .cmpDstFalse (cmpDstFalse),
    .wbValid     (wbValid),
    .wbPredIdx   (wbPredIdx),
    .wbDstReg    (wbDstReg),
    .wbData      (wbData),
    .cmpQualBit  (cmpQualBit),
    .wbQualBit   (wbQualBit),
    .rfWrEn      (rfWrEn),
    .rfWrAddr    (rfWrAddr),
    .rfWrData    (rfWrData)
  );

endmodule

// File: tb/pred_gate_unit_tb.sv
`timescale 1ns/1ps
module pred_gate_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpValid = 1'b0;
  logic [5:0]  cmpQualIdx = '0;
  logic [1:0]  cmpCond = '0;
  logic [63:0] cmpOpA = '0;
  logic [63:0] cmpOpB = '0;
  logic [5:0]  cmpDstTrue = '0;
  logic [5:0]  cmpDstFalse = '0;
  logic        wbValid = 1'b0;
  logic [5:0]  wbPredIdx = '0;
  logic [6:0]  wbDstReg = '0;
  logic [63:0] wbData = '0;
  logic        rfWrEn;
  logic [6:0]  rfWrAddr;
  logic [63:0] rfWrData;

  always #2.5 clk = ~clk;

  pred_gate_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmpValid(cmpValid), .cmpQualIdx(cmpQualIdx), .cmpCond(cmpCond),
    .cmpOpA(cmpOpA), .cmpOpB(cmpOpB),
    .cmpDstTrue(cmpDstTrue), .cmpDstFalse(cmpDstFalse),
    .wbValid(wbValid), .wbPredIdx(wbPredIdx), .wbDstReg(wbDstReg), .wbData(wbData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

  typedef struct {
    logic        en;
    logic [6:0]  addr;
    logic [63:0] data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [63:0] model;
  int checks = 0;
  int fails = 0;

  function automatic logic evalCond(logic [1:0] c, logic [63:0] a, logic [63:0] b);
    case (c)
      2'b00:   return a == b;
      2'b01:   return a != b;
      2'b10:   return $signed(a) < $signed(b);
      default: return a < b;
    endcase
  endfunction

  // one driven cycle: predict the writeback from the old model, then apply the compare
  task automatic step(input logic cv, input logic [5:0] qi, input logic [1:0] cc,
                      input logic [63:0] a, input logic [63:0] b,
                      input logic [5:0] dt, input logic [5:0] df,
                      input logic wv, input logic [5:0] pi, input logic [6:0] rg,
                      input logic [63:0] d, input string tag);
    expItem_t it;
    logic r;
    @(negedge clk);
    cmpValid = cv; cmpQualIdx = qi; cmpCond = cc; cmpOpA = a; cmpOpB = b;
    cmpDstTrue = dt; cmpDstFalse = df;
    wbValid = wv; wbPredIdx = pi; wbDstReg = rg; wbData = d;
    it.en = wv && model[pi]; it.addr = rg; it.data = d; it.tag = tag;
    expQ.push_back(it);
    if (cv && model[qi]) begin
      r = evalCond(cc, a, b);
      if (df != 0) model[df] = ~r;
      if (dt != 0) model[dt] = r;
    end
  endtask

  task automatic wb(input logic [5:0] pi, input logic [6:0] rg, input logic [63:0] d,
                    input string tag);
    step(1'b0, 6'd0, 2'd0, '0, '0, 6'd0, 6'd0, 1'b1, pi, rg, d, tag);
  endtask

  task automatic cmp(input logic [5:0] qi, input logic [1:0] cc, input logic [63:0] a,
                     input logic [63:0] b, input logic [5:0] dt, input logic [5:0] df);
    step(1'b1, qi, cc, a, b, dt, df, 1'b0, 6'd0, 7'd0, '0, "idle");
  endtask

  // monitor: each item is due one edge after it was driven
  always @(posedge clk) begin
    expItem_t it;
    #1;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      checks++;
      if (rfWrEn !== it.en ||
          (it.en && (rfWrAddr !== it.addr || rfWrData !== it.data))) begin
        fails++;
        $display("FAIL %s: en/addr/data = %0b/%0d/%h expected %0b/%0d/%h",
                 it.tag, rfWrEn, rfWrAddr, rfWrData, it.en, it.addr, it.data);
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles %0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = 64'h1;
    repeat (3) @(negedge clk);
    checks++;
    if (rfWrEn !== 1'b0) begin
      fails++;
      $display("FAIL R1: rfWrEn in reset %0b expected 0", rfWrEn);
    end
    rst_n = 1'b1;

    wb(6'd5, 7'd3, 64'hA, "R1 reset pred 5 clear");
    wb(6'd63, 7'd4, 64'hB, "R1 reset pred 63 clear");
    wb(6'd0, 7'd127, 64'hDEAD_BEEF_0000_0001, "R2 index 0 guard");

    cmp(6'd0, 2'b00, 64'd7, 64'd7, 6'd1, 6'd2);
    wb(6'd1, 7'd10, 64'h11, "R4 true destination");
    wb(6'd2, 7'd11, 64'h22, "R4 false destination");

    // same-cycle rule: flip p1/p2 while writing under p1
    step(1'b1, 6'd0, 2'b01, 64'd7, 64'd7, 6'd1, 6'd2, 1'b1, 6'd1, 7'd12, 64'h33,
         "R8 same cycle old value");
    wb(6'd1, 7'd13, 64'h44, "R8 next cycle new value");
    wb(6'd2, 7'd14, 64'h55, "R8 next cycle new value");

    // condition sweep
    for (int k = 0; k < 4; k++) begin
      logic [63:0] av [4];
      logic [63:0] bv [4];
      av = '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd9, 64'h8000_0000_0000_0000};
      bv = '{64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9, 64'd0};
      for (int c = 0; c < 4; c++) begin
        cmp(6'd0, 2'(c), av[k], bv[k], 6'd20, 6'd21);
        wb(6'd20, 7'(c), 64'(k), "R5 condition outcome");
        wb(6'd21, 7'(c + 8), 64'(k), "R5 condition inverse");
      end
    end

    // unqualified compare: p2 currently 1 from R8, p1 is 0
    cmp(6'd1, 2'b00, 64'd1, 64'd1, 6'd30, 6'd2);
    wb(6'd30, 7'd20, 64'h66, "R6 unqualified true dest unchanged");
    wb(6'd2, 7'd21, 64'h77, "R6 unqualified false dest unchanged");

    // same destination keeps the outcome
    cmp(6'd0, 2'b00, 64'd1, 64'd1, 6'd9, 6'd8);
    cmp(6'd0, 2'b00, 64'd3, 64'd4, 6'd9, 6'd9);
    wb(6'd9, 7'd22, 64'h88, "R7 shared destination outcome 0");
    cmp(6'd0, 2'b01, 64'd3, 64'd4, 6'd9, 6'd9);
    wb(6'd9, 7'd23, 64'h99, "R7 shared destination outcome 1");

    // writes to index 0 are ignored
    cmp(6'd0, 2'b00, 64'd5, 64'd5, 6'd10, 6'd0);
    wb(6'd0, 7'd24, 64'hAA, "R2 false dest 0 ignored");
    cmp(6'd0, 2'b01, 64'd5, 64'd5, 6'd0, 6'd10);
    wb(6'd0, 7'd25, 64'hBB, "R2 true dest 0 ignored");

    // both arms of a converted branch
    cmp(6'd0, 2'b10, 64'd2, 64'd6, 6'd11, 6'd12);
    wb(6'd11, 7'd40, 64'h1111, "R9 taken arm commits");
    wb(6'd12, 7'd41, 64'h2222, "R9 other arm suppressed");
    cmp(6'd0, 2'b10, 64'd6, 64'd2, 6'd11, 6'd12);
    wb(6'd11, 7'd42, 64'h3333, "R9 arm suppressed after flip");
    wb(6'd12, 7'd43, 64'h4444, "R9 arm commits after flip");
    step(1'b0, 6'd0, 2'd0, '0, '0, 6'd0, 6'd0, 1'b0, 6'd0, 7'd44, 64'h5555,
         "R3 invalid request");

    @(negedge clk);
    cmpValid = 1'b0; wbValid = 1'b0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule